// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Access Checks

This block sits between a pipeline stage and the memory system. It holds a small set of recently used page mappings and translates a 32-bit virtual address into a physical address. Each lookup carries an access kind (load, store or instruction fetch) and a privilege flag. The answer comes back in the cycle after the request. The answer is one of four: a physical address, a miss, a page fault, or a protection fault. Pages are 4 KB. The low 12 address bits pass through untranslated and the upper 20 bits are the page number.

On a miss, an external table walker loads a new mapping through the fill port, and the requester then repeats the access. A walker that finds no mapping can load an entry marked not-mapped, so the repeated access reports a page fault. Victims are taken in strict rotation over all slots. A flush input invalidates every slot at once. Every slot keeps a used flag and a modified flag. The response reports the values these flags had before the access, so the surrounding logic can see the first touch and the first store to a page.

Top module: `tlb_xlate`

## Requirements
- R1: After synchronous reset, every slot is invalid, all response outputs are 0, and a lookup of any address reports a miss.
- R2: The result of a request sampled at clock edge N is presented on the response outputs after edge N, together with resp_valid=1. When req_valid was 0 at that edge, resp_valid and all three fault/miss flags are 0.
- R3: A lookup whose page number matches no valid slot raises resp_miss with resp_paddr=0.
- R4: A permitted hit returns resp_paddr = {stored physical page number, req_vaddr[11:0]}, with no flag raised.
- R5: The access kind encoding is 2'b00 load, 2'b01 store, 2'b10 fetch, and 2'b11 reserved. A load needs the read right, a store needs the write right, and a fetch needs the execute right. A reserved kind is never permitted. A hit without the needed right raises resp_prot_fault with resp_paddr=0.
- R6: With req_user=1, a hit on a slot whose user right is clear raises resp_prot_fault. With req_user=0, the user right is not checked.
- R7: A hit on a slot loaded with fill_mapped=0 raises resp_page_fault, whatever the access kind and rights, with resp_paddr=0.
- R8: A permitted hit sets the slot's used flag. resp_prev_ref returns the flag's value before the access. Faulting accesses leave it unchanged.
- R9: A permitted store hit sets the slot's modified flag. resp_prev_dirty returns its value before the access. Loads, fetches and faulting stores leave it unchanged.
- R10: Fills go to slots 0, 1, 2 and so on in order, and wrap after the last slot. With ENTRIES slots, fill number ENTRIES+1 replaces the mapping loaded first.
- R11: A fill clears the used and modified flags of the slot it writes.
- R12: A flush invalidates all slots at the next edge and returns the fill position to slot 0. A fill in the same cycle as a flush is discarded.
- R13: When more than one valid slot holds the same page number, the lowest-numbered slot supplies the result.
- R14: At most one of resp_miss, resp_page_fault and resp_prot_fault is 1 at any time. Whenever any of them is 1, resp_paddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| req_user | input | 1 | 1 for user-privilege access, 0 for kernel |
| flush | input | 1 | Invalidate all slots |
| fill_valid | input | 1 | Load a new mapping |
| fill_vpn | input | 20 | Virtual page number of the new mapping |
| fill_ppn | input | 20 | Physical page number of the new mapping |
| fill_rd | input | 1 | Read right |
| fill_wr | input | 1 | Write right |
| fill_ex | input | 1 | Execute right |
| fill_usr | input | 1 | User-accessible right |
| fill_mapped | input | 1 | 0 marks the page as not present |
| resp_valid | output | 1 | Response present |
| resp_paddr | output | 32 | Translated physical address, 0 unless permitted hit |
| resp_miss | output | 1 | No matching slot |
| resp_page_fault | output | 1 | Matching slot marks the page not present |
| resp_prot_fault | output | 1 | Access kind or privilege not allowed |
| resp_prev_ref | output | 1 | Used flag before this access (permitted hits) |
| resp_prev_dirty | output | 1 | Modified flag before this access (permitted hits) |

## Verification
A wrong internal state shows up at the ports on the next lookup of the affected page. The response appears one cycle after the request. A stale valid bit after a flush shows as a hit where a miss is due. A victim pointer that is off by one shows as the wrong mapping surviving a wrap, or as the wrong duplicate winning. A lost or spurious flag update shows through resp_prev_ref and resp_prev_dirty on the following access to the same page. The bench therefore always follows a state-changing step with a lookup that exposes it within two cycles.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic usr;
    logic mapped;
  } slot_rights_t;

  // Rights test for a mapped slot; the privilege test is skipped in kernel mode.
  function automatic logic rights_allow(slot_rights_t r, acc_kind_e k, logic user);
    logic kind_ok;
    case (k)
      ACC_LOAD:  kind_ok = r.rd;
      ACC_STORE: kind_ok = r.wr;
      ACC_FETCH: kind_ok = r.ex;
      default:   kind_ok = 1'b0;
    endcase
    return kind_ok && (!user || r.usr);
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            slot_vld,
  input  logic [ENTRIES-1:0][VPN_W-1:0] slot_tag,
  input  logic [VPN_W-1:0]              key,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);

  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = slot_vld[g] && (slot_tag[g] == key);
  end

  // Scan from the top so the lowest matching slot is the last one assigned.
  always_comb begin
    hit_o = |match_vec;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    if (hit_o) begin
      AST_SEL_IS_MATCH: assert (match_vec[idx_o]); // R13
      AST_SEL_IS_LOWEST: assert ((match_vec & ((ENTRIES'(1) << idx_o) - ENTRIES'(1))) == '0); // R13
    end
  end

endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr_o
);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ptr_q <= '0;
    end else if (advance) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_q <= '0;
      else                              ptr_q <= ptr_q + IDX_W'(1);
    end
  end

  assign ptr_o = ptr_q;

  AST_PTR_FLUSH_ZERO: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ptr_o == '0)); // R12

  AST_PTR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!flush && !advance) |=> $stable(ptr_o)); // R10

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic             flush,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             fill_ex,
  input  logic             fill_usr,
  input  logic             fill_mapped,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_miss,
  output logic             resp_page_fault,
  output logic             resp_prot_fault,
  output logic             resp_prev_ref,
  output logic             resp_prev_dirty
);
  import tlb_pkg::*;

  // Slot storage: control flags are reset, payload fields are not.
  logic [ENTRIES-1:0]            vld_q, ref_q, dirty_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  slot_rights_t [ENTRIES-1:0]    rights_q;

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] victim;
  logic [VPN_W-1:0] req_vpn;
  acc_kind_e        kind;
  slot_rights_t     hit_rights;
  logic             allowed, granted, do_fill;

  assign req_vpn    = req_vaddr[VA_W-1:OFS_W];
  assign kind       = acc_kind_e'(req_kind);
  assign hit_rights = rights_q[hit_idx];
  assign allowed    = rights_allow(hit_rights, kind, req_user);
  assign granted    = req_valid && hit && hit_rights.mapped && allowed;
  assign do_fill    = fill_valid && !flush;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .slot_vld (vld_q),
    .slot_tag (tag_q),
    .key      (req_vpn),
    .hit_o    (hit),
    .idx_o    (hit_idx)
  );

  tlb_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .advance (do_fill),
    .ptr_o   (victim)
  );

  // Flags: flush beats everything; a fill overrides a same-slot status update.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else if (flush) begin
      vld_q   <= '0;
    end else begin
      if (granted) begin
        ref_q[hit_idx] <= 1'b1;
        if (kind == ACC_STORE) dirty_q[hit_idx] <= 1'b1;
      end
      if (do_fill) begin
        vld_q[victim]   <= 1'b1;
        ref_q[victim]   <= 1'b0;
        dirty_q[victim] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[victim]    <= fill_vpn;
      ppn_q[victim]    <= fill_ppn;
      rights_q[victim] <= '{rd: fill_rd, wr: fill_wr, ex: fill_ex,
                            usr: fill_usr, mapped: fill_mapped};
    end
  end

  // Registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid      <= 1'b0;
      resp_paddr      <= '0;
      resp_miss       <= 1'b0;
      resp_page_fault <= 1'b0;
      resp_prot_fault <= 1'b0;
      resp_prev_ref   <= 1'b0;
      resp_prev_dirty <= 1'b0;
    end else begin
      resp_valid      <= req_valid;
      resp_miss       <= req_valid && !hit;
      resp_page_fault <= req_valid && hit && !hit_rights.mapped;
      resp_prot_fault <= req_valid && hit && hit_rights.mapped && !allowed;
      resp_paddr      <= granted ? {ppn_q[hit_idx], req_vaddr[OFS_W-1:0]} : '0;
      resp_prev_ref   <= granted && ref_q[hit_idx];
      resp_prev_dirty <= granted && dirty_q[hit_idx];
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $countones({resp_miss, resp_page_fault, resp_prot_fault}) <= 1); // R14

  AST_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> !(resp_miss || resp_page_fault || resp_prot_fault)); // R2

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (resp_miss || resp_page_fault || resp_prot_fault) |-> (resp_paddr == '0)); // R14

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0)); // R12

  AST_STORE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (granted && kind == ACC_STORE && !flush && !(do_fill && victim == hit_idx))
      |=> dirty_q[$past(hit_idx)]); // R9

endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic        flush = 1'b0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        fill_rd = 1'b0, fill_wr = 1'b0, fill_ex = 1'b0, fill_usr = 1'b0, fill_mapped = 1'b0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic        resp_miss, resp_page_fault, resp_prot_fault, resp_prev_ref, resp_prev_dirty;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  tlb_xlate dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .flush(flush),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_ex(fill_ex), .fill_usr(fill_usr),
    .fill_mapped(fill_mapped), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_miss(resp_miss), .resp_page_fault(resp_page_fault),
    .resp_prot_fault(resp_prot_fault), .resp_prev_ref(resp_prev_ref),
    .resp_prev_dirty(resp_prev_dirty)
  );

  // Outcome codes: 0 translated, 1 miss, 2 page fault, 3 protection fault
  typedef struct packed {
    logic [1:0]  kind;
    logic        user;
    logic [31:0] va;
    logic [1:0]  code;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 32'h0001_0123, 2'd0, 32'h8001_0123},  // R4 load
    '{2'd1, 1'b1, 32'h0001_0FFF, 2'd0, 32'h8001_0FFF},  // R4 store
    '{2'd2, 1'b1, 32'h0001_0000, 2'd0, 32'h8001_0000},  // R4 fetch
    '{2'd0, 1'b1, 32'h0002_0456, 2'd0, 32'h8002_0456},  // R4 read-only page
    '{2'd1, 1'b1, 32'h0002_0456, 2'd3, 32'h0},          // R5 store w/o write right
    '{2'd2, 1'b1, 32'h0002_0000, 2'd3, 32'h0},          // R5 fetch w/o execute right
    '{2'd0, 1'b0, 32'h0003_0ABC, 2'd0, 32'h8003_0ABC},  // R6 kernel on kernel page
    '{2'd0, 1'b1, 32'h0003_0ABC, 2'd3, 32'h0},          // R6 user on kernel page
    '{2'd2, 1'b0, 32'h0003_0001, 2'd0, 32'h8003_0001},  // R6 kernel fetch
    '{2'd1, 1'b0, 32'h0003_0001, 2'd3, 32'h0},          // R5 kernel store w/o right
    '{2'd0, 1'b1, 32'h0004_0010, 2'd2, 32'h0},          // R7 not mapped
    '{2'd1, 1'b0, 32'h0004_0010, 2'd2, 32'h0},          // R7 not mapped, kernel
    '{2'd0, 1'b1, 32'h0006_0000, 2'd1, 32'h0},          // R3 miss
    '{2'd1, 1'b1, 32'h0005_0777, 2'd0, 32'h8ABC_D777},  // R4 write-only page
    '{2'd0, 1'b1, 32'h0005_0777, 2'd3, 32'h0},          // R5 load w/o read right
    '{2'd3, 1'b0, 32'h0001_0000, 2'd3, 32'h0},          // R5 reserved kind
    '{2'd0, 1'b0, 32'hFFFF_F000, 2'd1, 32'h0}           // R3 miss top page
  };

  task automatic do_fill(input logic [19:0] v, input logic [19:0] p,
                         input logic r, input logic w, input logic x,
                         input logic u, input logic m);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = p;
    fill_rd = r; fill_wr = w; fill_ex = x; fill_usr = u; fill_mapped = m;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic do_lookup(input logic [1:0] k, input logic u, input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_user = u; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic int got_code();
    if (resp_miss) return 1;
    if (resp_page_fault) return 2;
    if (resp_prot_fault) return 3;
    return 0;
  endfunction

  task automatic check_resp(input string req, input int code, input logic [31:0] pa);
    int nflags;
    nflags = int'(resp_miss) + int'(resp_page_fault) + int'(resp_prot_fault);
    n_chk++;
    if (resp_valid !== 1'b1 || nflags > 1 || got_code() != code || resp_paddr !== pa) begin
      n_bad++;
      $display("FAIL %s: valid=%b code=%0d flags=%0d pa=%h, expected valid=1 code=%0d pa=%h",
               req, resp_valid, got_code(), nflags, resp_paddr, code, pa);
    end
  endtask

  task automatic check_flags(input string req, input logic eref, input logic edirty);
    n_chk++;
    if (resp_prev_ref !== eref || resp_prev_dirty !== edirty) begin
      n_bad++;
      $display("FAIL %s: prev_ref=%b prev_dirty=%b, expected %b %b",
               req, resp_prev_ref, resp_prev_dirty, eref, edirty);
    end
  endtask

  task automatic check_idle(input string req);
    n_chk++;
    if (resp_valid !== 1'b0 || resp_miss !== 1'b0 || resp_page_fault !== 1'b0 ||
        resp_prot_fault !== 1'b0 || resp_paddr !== 32'h0) begin
      n_bad++;
      $display("FAIL %s: valid=%b miss=%b pf=%b prot=%b pa=%h, expected all 0",
               req, resp_valid, resp_miss, resp_page_fault, resp_prot_fault, resp_paddr);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 reset outputs");
    do_lookup(2'd0, 1'b0, 32'h0001_0123);
    check_resp("R1 empty after reset", 1, 32'h0);
    @(negedge clk);
    check_idle("R2 no request gives no response");

    // Table setup: slots 0..4
    do_fill(20'h00010, 20'h80010, 1, 1, 1, 1, 1);
    do_fill(20'h00020, 20'h80020, 1, 0, 0, 1, 1);
    do_fill(20'h00030, 20'h80030, 1, 0, 1, 0, 1);
    do_fill(20'h00040, 20'h00000, 1, 1, 1, 1, 0);
    do_fill(20'h00050, 20'h8ABCD, 0, 1, 0, 1, 1);
    for (int i = 0; i < NV; i++) begin
      do_lookup(VECS[i].kind, VECS[i].user, VECS[i].va);
      check_resp($sformatf("R2/R3-R7 vector %0d", i), int'(VECS[i].code), VECS[i].pa);
    end

    // Used and modified flags
    do_flush();
    do_lookup(2'd0, 1'b1, 32'h0001_0123);
    check_resp("R12 flush removes mapping", 1, 32'h0);
    do_fill(20'h00070, 20'h12345, 1, 1, 0, 1, 1);
    do_fill(20'h00071, 20'h23456, 1, 0, 0, 1, 1);
    do_lookup(2'd0, 1'b1, 32'h0007_0010);
    check_flags("R8 first touch", 1'b0, 1'b0);
    do_lookup(2'd0, 1'b1, 32'h0007_0010);
    check_flags("R8 second touch", 1'b1, 1'b0);
    do_lookup(2'd1, 1'b1, 32'h0007_0020);
    check_flags("R9 first store", 1'b1, 1'b0);
    do_lookup(2'd0, 1'b1, 32'h0007_0020);
    check_flags("R9 after store", 1'b1, 1'b1);
    do_lookup(2'd1, 1'b1, 32'h0007_1000);
    check_resp("R5 faulting store", 3, 32'h0);
    check_flags("R8 fault reports no flags", 1'b0, 1'b0);
    do_lookup(2'd0, 1'b1, 32'h0007_1000);
    check_flags("R9 faulting store leaves flags clear", 1'b0, 1'b0);

    // Rotation and flag clearing on refill
    do_flush();
    do_fill(20'h00100, 20'h00500, 1, 1, 1, 1, 1);
    do_lookup(2'd1, 1'b1, 32'h0010_0000);
    for (int i = 1; i < 32; i++)
      do_fill(20'(32'h100 + i), 20'(32'h500 + i), 1, 1, 1, 1, 1);
    do_fill(20'h00100, 20'h00777, 1, 1, 1, 1, 1);
    do_lookup(2'd0, 1'b1, 32'h0010_0ABC);
    check_resp("R10 wrap reuses slot 0", 0, 32'h0077_7ABC);
    check_flags("R11 refill clears flags", 1'b0, 1'b0);
    do_lookup(2'd0, 1'b1, 32'h0011_F004);
    check_resp("R10 last slot kept", 0, 32'h0051_F004);
    do_fill(20'h00999, 20'h00AAA, 1, 1, 1, 1, 1);
    do_lookup(2'd0, 1'b1, 32'h0010_1000);
    check_resp("R10 oldest remaining evicted", 1, 32'h0);
    do_lookup(2'd0, 1'b1, 32'h0099_9001);
    check_resp("R10 newest present", 0, 32'h00AA_A001);

    // Flush resets the pointer; lowest duplicate wins
    do_flush();
    for (int i = 0; i < 31; i++)
      do_fill(20'(32'h200 + i), 20'(32'h600 + i), 1, 1, 1, 1, 1);
    do_fill(20'h00300, 20'h00111, 1, 1, 1, 1, 1);
    do_lookup(2'd0, 1'b1, 32'h0030_0042);
    check_resp("R13 single copy", 0, 32'h0011_1042);
    do_fill(20'h00300, 20'h00222, 1, 1, 1, 1, 1);
    do_lookup(2'd0, 1'b1, 32'h0030_0042);
    check_resp("R12/R13 pointer at 0 after flush, lowest slot wins", 0, 32'h0022_2042);
    do_lookup(2'd0, 1'b1, 32'h0020_0000);
    check_resp("R10 slot 0 replaced", 1, 32'h0);

    // Fill during flush is dropped
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00444; fill_ppn = 20'h00555;
    fill_rd = 1; fill_wr = 1; fill_ex = 1; fill_usr = 1; fill_mapped = 1;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    do_lookup(2'd0, 1'b0, 32'h0044_4000);
    check_resp("R12 fill during flush dropped", 1, 32'h0);
    do_lookup(2'd0, 1'b0, 32'h0030_0000);
    check_resp("R12 old entries gone", 1, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule